// File: doc/BRIEF.md
# Multiframe-Aligned SYSREF Generator with Local Multiframe Counter

This block lives entirely in the link clock domain of a serial converter receiver. It emits a one-clock SYSREF pulse once per multiframe. A multiframe lasts K frames of F octets, and the link carries four octets per clock, so the pulse period is (K×F)/4 link clocks. The frame and octet counts are parameters, and a combination that does not give a whole number of link clocks stops elaboration.

The block also detects the rising edge of its own pulse with a registered edge detector. An accepted edge restarts a local multiframe counter at a programmable offset, which moves the boundary position used for deterministic latency. A boundary strobe marks each counter wrap. In single-detection mode only the first edge after reset or a re-arm is accepted, and later edges leave the counter running freely. In continuous mode every edge realigns the counter. A three-bit status word reports whether the first edge is still awaited, whether an edge was ignored, and whether alignment has taken place.

Top module: `sysref_lmfc_gen`

## Requirements
- R1: `sysref_o` is high for exactly one link clock, and successive pulses are MF_CLKS = K_FRAMES×F_OCTETS/4 clocks apart in both modes.
- R2: After reset is released, `sysref_o` first reads high after the MF_CLKS-th rising clock edge.
- R3: A rising edge of `sysref_o` is registered and accepted in the following cycle. At the clock edge after that, `lmfc_phase_o` takes the effective offset.
- R4: With `cont_mode_i` = 0, only the first rising edge after reset or re-arm realigns the counter. A later edge leaves the phase running on, even when `lmfc_ofs_i` has changed.
- R5: With `cont_mode_i` = 1, every rising edge realigns the counter to the current effective offset.
- R6: An offset value of MF_CLKS or more is treated as MF_CLKS-1.
- R7: `lmfc_edge_o` is high in exactly those cycles in which `lmfc_phase_o` is 0.
- R8: Between realignments, `lmfc_phase_o` counts 0,1,…,MF_CLKS-1 and then wraps to 0.
- R9: `det_status_o[2]` (first edge pending) is 1 after reset and after re-arm. It drops to 0 at the clock edge that accepts an edge.
- R10: `det_status_o[1]` becomes 1 when an edge is ignored in single-detection mode and stays 1 until re-arm or reset. `det_status_o[0]` becomes 1 when an edge is accepted and stays 1 until re-arm or reset.
- R11: `rearm_i` high at a clock edge sets `det_status_o` to 3'b100 at that edge. This holds even when an edge is accepted at the same edge, and in that case the realignment still happens.
- R12: Synchronous reset gives `sysref_o` = 0, `lmfc_phase_o` = 0, `lmfc_edge_o` = 1 and `det_status_o` = 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_mode_i | input | 1 | 1 = realign on every edge, 0 = first edge only |
| lmfc_ofs_i | input | PHASE_W | Counter value loaded on an accepted edge |
| rearm_i | input | 1 | Re-opens single detection and clears status |
| sysref_o | output | 1 | One-clock SYSREF pulse, once per multiframe |
| lmfc_edge_o | output | 1 | Multiframe boundary strobe |
| lmfc_phase_o | output | PHASE_W | Current multiframe counter value |
| det_status_o | output | 3 | {first edge pending, edge ignored, aligned} |

## Verification
The bench builds the block with K_FRAMES=20 and F_OCTETS=1. This gives a five-clock multiframe held in a three-bit phase. The wrap therefore happens at a count that is not a power of two, and offsets 5 to 7 reach the clamp of R6. A behavioural model of pulse timing, edge acceptance, phase and status is compared with every output on every clock. The stimulus covers offset changes in both modes, a re-arm that coincides with an accepted edge, and a reset in mid-run.

// File: rtl/sysref_lmfc_pkg.sv
package sysref_lmfc_pkg;

  // Octets carried per link clock on each lane.
  localparam int OCT_PER_CLK = 4;

  // Bit positions in the detection status word.
  localparam int ST_ALIGNED = 0;
  localparam int ST_IGNORED = 1;
  localparam int ST_PENDING = 2;
  localparam int ST_W       = 3;

  function automatic int mf_clks(input int k_frames, input int f_octets);
    return (k_frames * f_octets) / OCT_PER_CLK;
  endfunction

  function automatic int phase_bits(input int clks);
    return (clks > 1) ? $clog2(clks) : 1;
  endfunction

endpackage

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen #(
  parameter int MF_CLKS = 8,
  parameter int PHASE_W = 3
) (
  input  logic clk,
  input  logic rst,
  output logic sysref_o
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(MF_CLKS - 1);

  logic [PHASE_W-1:0] gen_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_cnt  <= '0;
      sysref_o <= 1'b0;
    end else begin
      gen_cnt  <= (gen_cnt == LAST) ? '0 : gen_cnt + 1'b1;
      sysref_o <= (gen_cnt == LAST);
    end
  end

  // Pulse is a single clock wide.
  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (rst)
    sysref_o |=> !sysref_o);

endmodule

// File: rtl/sysref_edge_det.sv
module sysref_edge_det
  import sysref_lmfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sysref_i,
  input  logic            cont_i,
  input  logic            rearm_i,
  output logic            accept_o,
  output logic [ST_W-1:0] status_o
);
  logic sref_prev;
  logic rise_q;
  logic pending_q;
  logic ignored_q;
  logic aligned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sref_prev <= 1'b0;
      rise_q    <= 1'b0;
    end else begin
      sref_prev <= sysref_i;
      rise_q    <= sysref_i & ~sref_prev;
    end
  end

  assign accept_o = rise_q & (pending_q | cont_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b1;
      ignored_q <= 1'b0;
      aligned_q <= 1'b0;
    end else if (rearm_i) begin
      pending_q <= 1'b1;
      ignored_q <= 1'b0;
      aligned_q <= 1'b0;
    end else if (accept_o) begin
      pending_q <= 1'b0;
      aligned_q <= 1'b1;
    end else if (rise_q && !cont_i) begin
      ignored_q <= 1'b1;
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[ST_PENDING] = pending_q;
    status_o[ST_IGNORED] = ignored_q;
    status_o[ST_ALIGNED] = aligned_q;
  end

  // An accepted edge must follow a high SYSREF sample.
  assert_accept_follows_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> $past(sysref_i));

  // The pending flag clears on the accepting edge unless re-armed.
  assert_pending_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (accept_o && !rearm_i) |=> !status_o[ST_PENDING]);

  // Re-arm restores the pending-only status word.
  assert_rearm_status_R11: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> (status_o == 3'b100));

endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
  parameter int MF_CLKS = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_i,
  input  logic [PHASE_W-1:0] ofs_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               edge_o
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(MF_CLKS - 1);

  logic [PHASE_W-1:0] ofs_eff;
  logic [PHASE_W-1:0] phase_nxt;

  assign ofs_eff = (ofs_i > LAST) ? LAST : ofs_i;

  always_comb begin
    if (accept_i)
      phase_nxt = ofs_eff;
    else if (phase_o == LAST)
      phase_nxt = '0;
    else
      phase_nxt = phase_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      edge_o  <= 1'b1;
    end else begin
      phase_o <= phase_nxt;
      edge_o  <= (phase_nxt == '0);
    end
  end

  // The clamped offset stays inside the multiframe.
  always_comb begin
    assert_ofs_in_range_R6: assert (ofs_eff <= LAST);
  end

  // Realignment loads the offset presented with the accept.
  assert_realign_R3: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> (phase_o == $past(ofs_eff)));

  // Free-running wrap at the end of the multiframe.
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!accept_i && phase_o == LAST) |=> (phase_o == '0));

  // Boundary strobe coincides with phase zero.
  assert_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (phase_o == '0));

endmodule

// File: rtl/sysref_lmfc_gen.sv
module sysref_lmfc_gen
  import sysref_lmfc_pkg::*;
#(
  parameter int K_FRAMES = 32,
  parameter int F_OCTETS = 1,
  localparam int MF_CLKS = mf_clks(K_FRAMES, F_OCTETS),
  localparam int PHASE_W = phase_bits(MF_CLKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cont_mode_i,
  input  logic [PHASE_W-1:0] lmfc_ofs_i,
  input  logic               rearm_i,
  output logic               sysref_o,
  output logic               lmfc_edge_o,
  output logic [PHASE_W-1:0] lmfc_phase_o,
  output logic [ST_W-1:0]    det_status_o
);
  generate
    if ((K_FRAMES * F_OCTETS) % OCT_PER_CLK != 0) begin : g_bad_ratio
      $error("multiframe octet count must be a multiple of the octets per link clock");
    end
    if (MF_CLKS < 2) begin : g_bad_len
      $error("multiframe must span at least two link clocks");
    end
  endgenerate

  logic accept;

  sysref_pulse_gen #(
    .MF_CLKS (MF_CLKS),
    .PHASE_W (PHASE_W)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .sysref_o (sysref_o)
  );

  sysref_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .sysref_i (sysref_o),
    .cont_i   (cont_mode_i),
    .rearm_i  (rearm_i),
    .accept_o (accept),
    .status_o (det_status_o)
  );

  lmfc_counter #(
    .MF_CLKS (MF_CLKS),
    .PHASE_W (PHASE_W)
  ) u_lmfc (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .ofs_i    (lmfc_ofs_i),
    .phase_o  (lmfc_phase_o),
    .edge_o   (lmfc_edge_o)
  );

  // In single mode no realignment happens while nothing is pending.
  assert_single_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!cont_mode_i && !det_status_o[ST_PENDING] && !rearm_i)
      |=> !det_status_o[ST_PENDING]);

endmodule

// File: tb/sysref_lmfc_gen_tb.sv
module sysref_lmfc_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KF = 20;
  localparam int FO = 1;
  localparam int L  = (KF * FO) / 4;
  localparam int PW = $clog2(L);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cont = 1'b0;
  logic [PW-1:0] ofs = '0;
  logic          rearm = 1'b0;
  logic          sysref;
  logic          bnd;
  logic [PW-1:0] phase;
  logic [2:0]    status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  sysref_lmfc_gen #(.K_FRAMES(KF), .F_OCTETS(FO)) u_dut (
    .clk(clk), .rst(rst), .cont_mode_i(cont), .lmfc_ofs_i(ofs), .rearm_i(rearm),
    .sysref_o(sysref), .lmfc_edge_o(bnd), .lmfc_phase_o(phase), .det_status_o(status)
  );

  // Behavioural reference model
  int m_cyc, m_phase;
  bit m_sref, m_prev, m_rise, m_pend, m_ign, m_algn;

  function automatic int clamp_ofs(input int v);
    return (v >= L) ? L - 1 : v;
  endfunction

  always @(posedge clk) begin
    bit acc, n_rise;
    if (rst) begin
      m_cyc = 0; m_sref = 0; m_prev = 0; m_rise = 0; m_phase = 0;
      m_pend = 1; m_ign = 0; m_algn = 0;
    end else begin
      acc    = m_rise && (m_pend || cont);
      n_rise = m_sref && !m_prev;
      m_prev = m_sref;
      m_cyc  = m_cyc + 1;
      m_sref = (m_cyc % L == 0);
      m_phase = acc ? clamp_ofs(int'(ofs)) : (m_phase + 1) % L;
      if (rearm) begin
        m_pend = 1; m_ign = 0; m_algn = 0;
      end else if (acc) begin
        m_pend = 0; m_algn = 1;
      end else if (m_rise && !cont) begin
        m_ign = 1;
      end
      m_rise = n_rise;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1", "sysref", int'(sysref), int'(m_sref));
      check(cur_tag, "phase", int'(phase), m_phase);
      check("R7", "boundary", int'(bnd), int'(m_phase == 0));
      check("R10", "status", int'(status), int'({m_pend, m_ign, m_algn}));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(3);
    // R12: reset values
    check("R12", "sysref in reset", int'(sysref), 0);
    check("R12", "phase in reset", int'(phase), 0);
    check("R12", "boundary in reset", int'(bnd), 1);
    check("R12", "status in reset", int'(status), 4);

    // R2: first pulse after L edges
    ofs = 3'd3;
    rst = 1'b0;
    run(L - 1);
    check("R2", "sysref before first pulse", int'(sysref), 0);
    run(1);
    check("R2", "first pulse", int'(sysref), 1);
    cur_tag = "R3";
    run(2);
    check("R3", "phase after first accept", int'(phase), 3);
    check("R9", "pending cleared", int'(status[2]), 0);

    // R4: later edges ignored in single mode, offset change has no effect
    cur_tag = "R4";
    run(3 * L);
    ofs = 3'd1;
    run(4 * L);
    check("R10", "ignored flag set", int'(status[1]), 1);

    // R11: re-arm opens detection again
    cur_tag = "R11";
    rearm = 1'b1;
    run(1);
    rearm = 1'b0;
    check("R11", "status after rearm", int'(status), 4);
    run(3 * L);

    // R5: continuous mode follows offset changes
    cur_tag = "R5";
    cont = 1'b1;
    ofs = 3'd4;
    run(3 * L);
    ofs = 3'd0;
    run(3 * L);

    // R6: out-of-range offsets clamp
    cur_tag = "R6";
    ofs = 3'd7;
    run(3 * L);
    ofs = 3'd5;
    run(3 * L);

    // R11: re-arm coinciding with an accepted edge
    cur_tag = "R11";
    cont = 1'b0;
    ofs = 3'd2;
    rearm = 1'b1;
    run(1);
    rearm = 1'b0;
    while (!sysref) run(1);
    run(1);
    rearm = 1'b1;
    run(1);
    rearm = 1'b0;
    check("R11", "pending kept after coincident rearm", int'(status), 4);
    check("R11", "realigned at coincident rearm", int'(phase), 2);
    ofs = 3'd0;
    run(3 * L);

    // R8: mid-run reset and free running
    cur_tag = "R8";
    @(negedge clk) rst = 1'b1;
    run(2);
    check("R12", "phase after mid reset", int'(phase), 0);
    check("R12", "status after mid reset", int'(status), 4);
    rst = 1'b0;
    run(4 * L);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule